// File: doc/BRIEF.md
# Indexed-Register and Paged-RAM Bus Bridge

This block sits behind an 8-bit, strobe-driven microprocessor bus and turns it into two separate access windows. The first window, picked by its own active-low select, holds a 6-bit index register and a data port. A write with address bit 0 low loads the index. An access with address bit 0 high reaches whichever of 64 internal byte registers the index names. The second window, picked by a second active-low select, holds a 7-bit page register and a 32-byte view into a 4096-byte RAM. When address bit 5 is high, every one of the 32 addresses reaches the page register. When it is low, address bits 4..0 pick the byte inside the current page.

Both the register file and the RAM are modelled inside the block. A write commits on the clock that follows the rising edge of the write strobe, and it uses the bus values that were last seen while the strobe was low. Reads are combinational from storage and are only driven while the read strobe is low. Two byte registers are fully read-only and one further register has a read-only top bit. An active-low standby input shuts the bus out completely.

Top module: `idxpage_bus_bridge`

## Requirements
- R1: After synchronous reset the index register and the page register are both 0, and every one of the 64 register-file bytes is 0.
- R2: In the register window (reg_sel_n low) with addr[0]=0, a write loads wdata[5:0] into the index. A read returns {2'b00, index}.
- R3: In the register window with addr[0]=1, reads and writes reach register-file byte number `index`. Address bits 5..1 have no effect.
- R4: In the RAM window (ram_sel_n low, reg_sel_n high) with addr[5]=1, a read or write reaches the 7-bit page register whatever addr[4:0] holds. Read data bit 7 is always 0.
- R5: In the RAM window with addr[5]=0, reads and writes reach RAM byte page*32 + addr[4:0].
- R6: A write takes effect only after wr_n returns high. It uses the select, address and data sampled on the last clock while wr_n was low. Storage is unchanged while wr_n is held low.
- R7: rdata_oe is 1 only while rd_n is low, stby_n is high and at least one select is low. Whenever rdata_oe is 0, rdata is 0.
- R8: Register-file bytes 12 and 13 ignore writes and keep reading 0. Bit 7 of byte 10 ignores writes and keeps reading 0, while its bits 6..0 are writable.
- R9: While stby_n is low, rdata_oe is 0. A write pulse during which stby_n was low on any sampled clock changes no storage.
- R10: When both selects are low, the access goes to the register window only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stby_n | input | 1 | Active-low standby; blocks all access |
| reg_sel_n | input | 1 | Active-low select of the indexed-register window |
| ram_sel_n | input | 1 | Active-low select of the paged-RAM window |
| addr | input | 6 | Bus address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 8 | Write data from the bus |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | Drive enable for an external tri-state data pad |

## Verification
The assertions assume that the bus inputs are already synchronous to clk. They also assume that a write strobe stays low for at least one sampled clock before it rises, so that a commit always has latched values behind it. The bench changes every bus input on the falling clock edge and holds wr_n low for at least one full rising edge in every write. Standby and both-select cases are driven as whole-cycle levels, so no input changes on the edge where the checker samples.

// File: rtl/idxpage_pkg.sv
// Shared sizes and the write-protection map of the indexed register file.
// Assumes an 8-bit bus; protected register numbers are fixed by the block's use.
package idxpage_pkg;
    localparam int DATA_W   = 8;
    localparam int IDX_W    = 6;
    localparam int PAGE_W   = 7;
    localparam int OFF_W    = 5;
    localparam int ADDR_W   = 6;
    localparam int NREGS    = 1 << IDX_W;

    localparam int RO_FULL_A = 12;
    localparam int RO_FULL_B = 13;
    localparam int RO_MSB    = 10;

    // Bits set in the result may be written for the given register number.
    function automatic logic [DATA_W-1:0] wr_mask(input int unsigned num);
        logic [DATA_W-1:0] m;
        m = '1;
        if (num == RO_FULL_A || num == RO_FULL_B) m = '0;
        else if (num == RO_MSB) m[DATA_W-1] = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/idxpage_wr_capture.sv
// Write-strobe capture: latches select, address and data on every clock that
// wr_n is low, then issues a one-cycle commit on the first clock wr_n is high.
// Assumes bus inputs are synchronous to clk. A standby level seen on any clock
// of the low pulse cancels the whole pulse.
module idxpage_wr_capture #(
    parameter int DATA_W = idxpage_pkg::DATA_W,
    parameter int ADDR_W = idxpage_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby_n,
    input  logic              reg_act,
    input  logic              ram_act,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output logic              c_reg,
    output logic              c_ram,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_data
);
    logic pend_q;
    logic abort_q;

    // Track the low phase of the strobe and hold the latest bus values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            abort_q <= 1'b0;
            c_reg   <= 1'b0;
            c_ram   <= 1'b0;
            c_addr  <= '0;
            c_data  <= '0;
        end else if (wr_n) begin
            pend_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            pend_q  <= reg_act | ram_act;
            abort_q <= abort_q | ~stby_n;
            c_reg   <= reg_act;
            c_ram   <= ram_act;
            c_addr  <= addr;
            c_data  <= wdata;
        end
    end

    // Commit on the first high sample after an accepted low phase.
    assign commit = wr_n & pend_q & ~abort_q & stby_n;
endmodule

// File: rtl/idxpage_reg_window.sv
// Indexed register window: a 6-bit index register plus a file of 64 bytes
// reached through a data port. Write protection comes from the package map.
// Assumes commit is a single-cycle pulse with stable c_a0/c_data.
module idxpage_reg_window #(
    parameter int DATA_W = idxpage_pkg::DATA_W,
    parameter int IDX_W  = idxpage_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              c_a0,
    input  logic [DATA_W-1:0] c_data,
    input  logic              rd_a0,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NREGS = 1 << IDX_W;
    localparam int PAD_W = DATA_W - IDX_W;

    logic [IDX_W-1:0]  index_q;
    logic [DATA_W-1:0] regs [NREGS];

    // Load the index from the low data bits on a port-0 write.
    always_ff @(posedge clk) begin
        if (!rst_n)                index_q <= '0;
        else if (wr_en && !c_a0)   index_q <= c_data[IDX_W-1:0];
    end

    // One storage byte per register number, each with its own write mask.
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = idxpage_pkg::wr_mask(g);
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && c_a0 && index_q == IDX_W'(g))
                regs[g] <= (regs[g] & ~MASK) | (c_data & MASK);
        end
    end

    // Port 0 returns the zero-extended index, port 1 the pointed byte.
    always_comb begin
        if (rd_a0) rd_data = regs[index_q];
        else       rd_data = {{PAD_W{1'b0}}, index_q};
    end
endmodule

// File: rtl/idxpage_ram_window.sv
// Paged RAM window: a 7-bit page register and a RAM of PAGES x 32 bytes.
// Address bit 5 high reaches the page register at every offset; low reaches
// a byte in the current page. RAM contents are not reset.
module idxpage_ram_window #(
    parameter int DATA_W = idxpage_pkg::DATA_W,
    parameter int PAGE_W = idxpage_pkg::PAGE_W,
    parameter int OFF_W  = idxpage_pkg::OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [OFF_W:0]     c_addr,
    input  logic [DATA_W-1:0]  c_data,
    input  logic [OFF_W:0]     rd_addr,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int MEM_A = PAGE_W + OFF_W;
    localparam int DEPTH = 1 << MEM_A;
    localparam int PAD_W = DATA_W - PAGE_W;

    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] mem [DEPTH];

    // Page register update on a write with the page-select bit high.
    always_ff @(posedge clk) begin
        if (!rst_n)                     page_q <= '0;
        else if (wr_en && c_addr[OFF_W]) page_q <= c_data[PAGE_W-1:0];
    end

    // Byte write into the current page.
    always_ff @(posedge clk) begin
        if (wr_en && !c_addr[OFF_W])
            mem[{page_q, c_addr[OFF_W-1:0]}] <= c_data;
    end

    // Read either the zero-extended page number or the addressed byte.
    always_comb begin
        if (rd_addr[OFF_W]) rd_data = {{PAD_W{1'b0}}, page_q};
        else                rd_data = mem[{page_q, rd_addr[OFF_W-1:0]}];
    end
endmodule

// File: rtl/idxpage_bus_bridge.sv
// Top of the two-window bus bridge. Decodes the selects (register window wins
// when both are low), routes commits from the strobe capture to the windows
// and muxes read data. Assumes inputs synchronous to clk.
module idxpage_bus_bridge #(
    parameter int DATA_W = idxpage_pkg::DATA_W,
    parameter int ADDR_W = idxpage_pkg::ADDR_W,
    parameter int IDX_W  = idxpage_pkg::IDX_W,
    parameter int PAGE_W = idxpage_pkg::PAGE_W,
    parameter int OFF_W  = idxpage_pkg::OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby_n,
    input  logic              reg_sel_n,
    input  logic              ram_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    logic              reg_act, ram_act;
    logic              commit, c_reg, c_ram;
    logic [ADDR_W-1:0] c_addr;
    logic [DATA_W-1:0] c_data;
    logic [DATA_W-1:0] reg_rd, ram_rd;

    // Window decode with register-window priority.
    assign reg_act = ~reg_sel_n;
    assign ram_act = ~ram_sel_n & reg_sel_n;

    idxpage_wr_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .stby_n(stby_n),
        .reg_act(reg_act), .ram_act(ram_act), .addr(addr),
        .wr_n(wr_n), .wdata(wdata),
        .commit(commit), .c_reg(c_reg), .c_ram(c_ram),
        .c_addr(c_addr), .c_data(c_data)
    );

    idxpage_reg_window #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(commit & c_reg),
        .c_a0(c_addr[0]), .c_data(c_data),
        .rd_a0(addr[0]), .rd_data(reg_rd)
    );

    idxpage_ram_window #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(commit & c_ram),
        .c_addr(c_addr[OFF_W:0]), .c_data(c_data),
        .rd_addr(addr[OFF_W:0]), .rd_data(ram_rd)
    );

    // Drive read data only during a strobed, selected, non-standby read.
    always_comb begin
        rdata_oe = ~rd_n & stby_n & (reg_act | ram_act);
        if (!rdata_oe)    rdata = '0;
        else if (reg_act) rdata = reg_rd;
        else              rdata = ram_rd;
    end
endmodule

// File: rtl/idxpage_checker.sv
// Property checker for the bus bridge, attached by bind. Watches ports plus
// the index, page and protected register contents.
module idxpage_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       stby_n,
    input logic       reg_sel_n,
    input logic       ram_sel_n,
    input logic [5:0] addr,
    input logic       rd_n,
    input logic       wr_n,
    input logic [7:0] rdata,
    input logic       rdata_oe,
    input logic [5:0] index_q,
    input logic [6:0] page_q,
    input logic [7:0] ro_a,
    input logic [7:0] ro_b,
    input logic [7:0] ro_msb
);
    assert_rst_state_R1: assert property (@(posedge clk)
        !rst_n |=> (index_q == 6'd0 && page_q == 7'd0));

    assert_index_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && !reg_sel_n && !addr[0]) |-> rdata[7:6] == 2'b00);

    assert_page_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && reg_sel_n && !ram_sel_n && addr[5]) |-> !rdata[7]);

    assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> ($stable(index_q) && $stable(page_q)));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> rdata == 8'h00);

    assert_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || (reg_sel_n && ram_sel_n)) |-> !rdata_oe);

    assert_protect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_a == 8'h00 && ro_b == 8'h00 && !ro_msb[7]));

    assert_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_n |=> ($stable(index_q) && $stable(page_q) && !$past(rdata_oe)));
endmodule

bind idxpage_bus_bridge idxpage_checker u_chk (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n),
    .reg_sel_n(reg_sel_n), .ram_sel_n(ram_sel_n), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .rdata_oe(rdata_oe),
    .index_q(u_regs.index_q), .page_q(u_ram.page_q),
    .ro_a(u_regs.regs[12]), .ro_b(u_regs.regs[13]), .ro_msb(u_regs.regs[10])
);

// File: tb/tb_idxpage_bus_bridge.sv
// Bench: a table of write/read vectors walked by one loop, then directed
// tests for reset, strobe timing, standby, select priority and idle drive.
module tb_idxpage_bus_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stby_n = 1'b1;
    logic       reg_sel_n = 1'b1;
    logic       ram_sel_n = 1'b1;
    logic [5:0] addr = '0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    idxpage_bus_bridge dut (
        .clk(clk), .rst_n(rst_n), .stby_n(stby_n),
        .reg_sel_n(reg_sel_n), .ram_sel_n(ram_sel_n), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // Entry: [31:28] req, [27] read, [26] ram window, [25:20] addr,
    // [15:8] write data, [7:0] expected read data.
    localparam int NV = 22;
    localparam logic [31:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b0, 6'h00, 4'h0, 8'hC5, 8'h00}, // R2 index <= 5
        {4'd2, 1'b1, 1'b0, 6'h00, 4'h0, 8'h00, 8'h05}, // R2 upper bits 0
        {4'd3, 1'b0, 1'b0, 6'h01, 4'h0, 8'hA7, 8'h00}, // R3 reg5 <= A7
        {4'd3, 1'b1, 1'b0, 6'h3F, 4'h0, 8'h00, 8'hA7}, // R3 addr[5:1] ignored
        {4'd8, 1'b0, 1'b0, 6'h00, 4'h0, 8'h0C, 8'h00}, // R8 index 12
        {4'd8, 1'b0, 1'b0, 6'h01, 4'h0, 8'hFF, 8'h00},
        {4'd8, 1'b1, 1'b0, 6'h01, 4'h0, 8'h00, 8'h00}, // R8 reg12 stays 0
        {4'd8, 1'b0, 1'b0, 6'h00, 4'h0, 8'h0D, 8'h00}, // R8 index 13
        {4'd8, 1'b0, 1'b0, 6'h01, 4'h0, 8'h55, 8'h00},
        {4'd8, 1'b1, 1'b0, 6'h01, 4'h0, 8'h00, 8'h00}, // R8 reg13 stays 0
        {4'd8, 1'b0, 1'b0, 6'h00, 4'h0, 8'h0A, 8'h00}, // R8 index 10
        {4'd8, 1'b0, 1'b0, 6'h01, 4'h0, 8'hFF, 8'h00},
        {4'd8, 1'b1, 1'b0, 6'h01, 4'h0, 8'h00, 8'h7F}, // R8 bit 7 stays 0
        {4'd4, 1'b0, 1'b1, 6'h20, 4'h0, 8'hFF, 8'h00}, // R4 page <= 7F
        {4'd4, 1'b1, 1'b1, 6'h3B, 4'h0, 8'h00, 8'h7F}, // R4 alias, bit7 0
        {4'd5, 1'b0, 1'b1, 6'h07, 4'h0, 8'h5A, 8'h00}, // R5 page7F byte7
        {4'd5, 1'b0, 1'b1, 6'h2A, 4'h0, 8'h01, 8'h00}, // R4 page <= 1 via alias
        {4'd5, 1'b0, 1'b1, 6'h07, 4'h0, 8'h3C, 8'h00}, // R5 page1 byte7
        {4'd5, 1'b1, 1'b1, 6'h07, 4'h0, 8'h00, 8'h3C},
        {4'd5, 1'b0, 1'b1, 6'h31, 4'h0, 8'h7F, 8'h00}, // back to page 7F
        {4'd5, 1'b1, 1'b1, 6'h07, 4'h0, 8'h00, 8'h5A}, // R5 pages distinct
        {4'd3, 1'b1, 1'b0, 6'h3E, 4'h0, 8'h00, 8'h0A}  // R3 port0 with high bits
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic select(input int win);
        reg_sel_n = !(win == 0 || win == 2);
        ram_sel_n = !(win == 1 || win == 2);
    endtask

    task automatic release_bus();
        reg_sel_n = 1'b1;
        ram_sel_n = 1'b1;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
    endtask

    // win: 0 register window, 1 RAM window, 2 both selects low.
    task automatic bus_write(input int win, input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        select(win); addr = a; wdata = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        release_bus();
    endtask

    task automatic bus_read(input string req, input int win, input logic [5:0] a,
                            input logic [7:0] exp);
        @(negedge clk);
        select(win); addr = a; rd_n = 1'b0;
        #1;
        check(req, {7'd0, rdata_oe}, 8'd1);
        check(req, rdata, exp);
        release_bus();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R7 idle output.
        @(negedge clk); #1;
        check("R7 idle oe", {7'd0, rdata_oe}, 8'd0);
        check("R7 idle data", rdata, 8'h00);
        bus_read("R1 index", 0, 6'h00, 8'h00);
        bus_read("R1 page", 1, 6'h20, 8'h00);
        bus_read("R1 reg0", 0, 6'h01, 8'h00);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][31:28], i);
            if (VEC[i][27])
                bus_read(tag, int'(VEC[i][26]), VEC[i][25:20], VEC[i][7:0]);
            else
                bus_write(int'(VEC[i][26]), VEC[i][25:20], VEC[i][15:8]);
        end

        // R6: state held while wr_n low, last low-cycle data wins.
        @(negedge clk);
        select(0); addr = 6'h00; wdata = 8'h11; wr_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b0; #1;
        check("R6 hold during low", rdata, 8'h0A);
        rd_n = 1'b1; wdata = 8'h22;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        release_bus();
        bus_read("R6 last data", 0, 6'h00, 8'h22);

        // R9: no drive in standby.
        @(negedge clk);
        stby_n = 1'b0; select(0); addr = 6'h00; rd_n = 1'b0; #1;
        check("R9 standby oe", {7'd0, rdata_oe}, 8'd0);
        check("R9 standby data", rdata, 8'h00);
        release_bus();
        // R9: write fully inside standby is dropped.
        bus_write(0, 6'h00, 8'h33);
        bus_write(1, 6'h20, 8'h05);
        @(negedge clk);
        stby_n = 1'b1;
        bus_read("R9 index kept", 0, 6'h00, 8'h22);
        bus_read("R9 page kept", 1, 6'h20, 8'h7F);
        // R9: one standby clock inside the pulse cancels it.
        @(negedge clk);
        select(0); addr = 6'h00; wdata = 8'h04; wr_n = 1'b0;
        @(negedge clk);
        stby_n = 1'b0;
        @(negedge clk);
        stby_n = 1'b1;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        release_bus();
        bus_read("R9 mid-pulse cancel", 0, 6'h00, 8'h22);

        // R10: both selects low go to the register window.
        bus_write(2, 6'h20, 8'h09);
        bus_read("R10 index written", 0, 6'h00, 8'h09);
        bus_read("R10 page untouched", 1, 6'h20, 8'h7F);
        bus_read("R10 read priority", 2, 6'h00, 8'h09);

        // R7: read strobe without a select is not driven.
        @(negedge clk);
        rd_n = 1'b1; addr = 6'h00; #1;
        rd_n = 1'b0; #1;
        check("R7 no select oe", {7'd0, rdata_oe}, 8'd0);
        check("R7 no select data", rdata, 8'h00);
        release_bus();

        // R1: a second reset clears index, page and registers.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read("R1 index after reset", 0, 6'h00, 8'h00);
        bus_read("R1 page after reset", 1, 6'h3F, 8'h00);
        bus_write(0, 6'h00, 8'h05);
        bus_read("R1 reg5 cleared", 0, 6'h01, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule